// File: doc/BRIEF.md
# Multi-Channel Temperature Threshold Monitor

This block watches five on-chip temperature channels: soc (0), package (1), gpu (2), cluster0 (3) and cluster1 (4). Each channel receives offset-encoded temperature codes through a valid/ready stream. A code equals the temperature in whole degrees Celsius plus 278, so software gets milli-degrees as (code − 278) × 1000. For every enabled channel, the block keeps the most recent code in a readable data word. It compares each accepted code against a high and a low limit programmed for that channel, and it records sticky above-limit and below-limit flags.

The flags can be masked per channel and are cleared by writing ones. A single level interrupt combines them under a global enable. A debounce filter sets how many consecutive accepted codes of the same class a channel must see before a flag is raised.

Software programs the block through a minimal register bus:
- Write strobe, address and write data.
- Read data that follows the address in the same cycle.

The sample streams never apply back-pressure outside reset. The ready outputs are high whenever reset is low. A code is taken on any rising clock edge where its valid and ready are both high. The sender may change the code on every cycle.

Top module: `thermal_watch`

## Requirements
- R1: After reset the following values hold:
  - Sensor-enable (0x08), timing (0x0C), status (0x18) and all data words read 0.
  - The interrupt-control register (0x14) reads 0x7FE.
  - Every limit register reads 0xFFFF0000.
  - `irq` is 0.
- R2: A code accepted on an enabled channel ch is stored and read back from the word at 0x20 + (ch/2)×4. Even channels use bits [15:0] and odd channels use bits [31:16]. Bits that no channel owns read 0.
- R3: A code presented to a channel whose bit in the sensor-enable register (0x08, bit ch) is 0 changes neither that channel's data nor its flags.
- R4: The limit register of channel ch sits at 0x40 + ch×4, with the high code in bits [31:16] and the low code in bits [15:0]. It reads back exactly what was written.
- R5: Status bit 2ch+1 sets when an accepted code is strictly greater than the high code. Status bit 2ch+2 sets when an accepted code is strictly less than the low code. A code equal to either limit sets nothing.
- R6: Filter period F is timing bits [21:20]. Each accepted code is classed as above, below or inside. A flag is raised only when the code is at least the (F+1)-th consecutive accepted code of its class on that channel.
- R7: Status flags are sticky whatever the mask says. Writing 1 to a bit position of the clear register (0x10) clears that flag. The clear register reads 0, and writes to the status register have no effect.
- R8: When a flag's raising event and a clear of the same bit occur in one cycle, the flag ends up set.
- R9: In the interrupt-control register, bit 0 is the global enable and bits 2ch+1 and 2ch+2 mask the matching flags (1 = masked). `irq` is 1 exactly when the global enable is 1 and some set flag has its mask bit 0, and it follows the flags and the register combinationally.
- R10: Only bits [23:0] of the timing register are stored; bits [31:24] read 0.
- R11: `smp_ready` is all zeros while `rst` is high and all ones otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| smp_valid | input | 5 | Per-channel sample valid |
| smp_code | input | 80 | Per-channel 16-bit codes, channel ch at bits [16ch+15:16ch] |
| smp_ready | output | 5 | Per-channel sample ready |
| irq | output | 1 | Combined level interrupt |

## Verification
Timing of each result:
- A register write becomes visible on the read path after the clock edge that samples it.
- A code accepted at an edge updates its data word and any flag at that same edge.
- `irq` follows the flags in the same cycle, with no extra register.

How the bench keeps to that timing:
- It drives every write and sample on the falling edge and lets exactly one rising edge pass.
- It updates its own model at that point.
- It compares `irq` and the read path in the following low phase, stepping the address with small delays.

This ordering also covers the cycle in which a clear and an event collide: the model applies the event after the clear, as R8 requires.

// File: rtl/twm_pkg.sv
package twm_pkg;

  localparam int unsigned TWM_ADDR_W   = 8;
  localparam int unsigned TWM_CODE_W   = 16;
  localparam int unsigned TWM_FILT_W   = 2;
  localparam int unsigned TWM_FILT_LSB = 20;
  localparam int unsigned TWM_TIME_W   = 24;

  localparam logic [TWM_ADDR_W-1:0] TWM_A_CHEN = 8'h08;
  localparam logic [TWM_ADDR_W-1:0] TWM_A_TIME = 8'h0C;
  localparam logic [TWM_ADDR_W-1:0] TWM_A_CLR  = 8'h10;
  localparam logic [TWM_ADDR_W-1:0] TWM_A_IEN  = 8'h14;
  localparam logic [TWM_ADDR_W-1:0] TWM_A_STS  = 8'h18;
  localparam logic [TWM_ADDR_W-1:0] TWM_A_DATA = 8'h20;
  localparam logic [TWM_ADDR_W-1:0] TWM_A_THR  = 8'h40;

  typedef enum logic [1:0] {
    TWM_CLS_IN = 2'd0,
    TWM_CLS_HI = 2'd1,
    TWM_CLS_LO = 2'd2
  } twm_cls_e;

endpackage

// File: rtl/twm_regs.sv
module twm_regs
  import twm_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CODE_W = TWM_CODE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic [TWM_ADDR_W-1:0]      bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_CH*CODE_W-1:0]   ch_data_i,
  input  logic [2*NUM_CH-1:0]        sts_i,
  output logic [NUM_CH-1:0]          ch_en_o,
  output logic [TWM_FILT_W-1:0]      filt_o,
  output logic [NUM_CH*CODE_W-1:0]   thr_hi_o,
  output logic [NUM_CH*CODE_W-1:0]   thr_lo_o,
  output logic [2*NUM_CH-1:0]        mask_o,
  output logic                       gen_o,
  output logic [2*NUM_CH-1:0]        clr_o
);

  localparam int unsigned IEN_W  = 2*NUM_CH + 1;
  localparam int unsigned PAIR_W = 2*CODE_W;
  localparam int unsigned NWORD  = (NUM_CH + 1) / 2;

  logic [NUM_CH-1:0]      en_q;
  logic [TWM_TIME_W-1:0]  time_q;
  logic [IEN_W-1:0]       ien_q;
  logic [PAIR_W-1:0]      thr_q [NUM_CH];
  logic [NWORD*PAIR_W-1:0] data_pad;
  logic                   unused_wdata;

  function automatic logic [TWM_ADDR_W-1:0] thr_addr(input int unsigned c);
    return TWM_A_THR + TWM_ADDR_W'(4*c);
  endfunction

  function automatic logic [TWM_ADDR_W-1:0] data_addr(input int unsigned w);
    return TWM_A_DATA + TWM_ADDR_W'(4*w);
  endfunction

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      time_q <= '0;
      ien_q  <= {{(IEN_W-1){1'b1}}, 1'b0};
      for (int c = 0; c < NUM_CH; c++) begin
        thr_q[c] <= {{CODE_W{1'b1}}, {CODE_W{1'b0}}};
      end
    end else if (bus_wr) begin
      if (bus_addr == TWM_A_CHEN) en_q   <= bus_wdata[NUM_CH-1:0];
      if (bus_addr == TWM_A_TIME) time_q <= bus_wdata[TWM_TIME_W-1:0];
      if (bus_addr == TWM_A_IEN)  ien_q  <= bus_wdata[IEN_W-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_addr == thr_addr(c)) thr_q[c] <= bus_wdata[PAIR_W-1:0];
      end
    end
  end

  // clear pulses only exist in the write cycle
  assign clr_o = (bus_wr && bus_addr == TWM_A_CLR) ? bus_wdata[IEN_W-1:1] : '0;

  assign ch_en_o = en_q;
  assign filt_o  = time_q[TWM_FILT_LSB +: TWM_FILT_W];
  assign gen_o   = ien_q[0];
  assign mask_o  = ien_q[IEN_W-1:1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_thr
    assign thr_hi_o[c*CODE_W +: CODE_W] = thr_q[c][PAIR_W-1 -: CODE_W];
    assign thr_lo_o[c*CODE_W +: CODE_W] = thr_q[c][CODE_W-1:0];
  end

  // channels are packed pairwise; the missing odd partner reads zero
  assign data_pad = (NWORD*PAIR_W)'(ch_data_i);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      TWM_A_CHEN: bus_rdata = 32'(en_q);
      TWM_A_TIME: bus_rdata = 32'(time_q);
      TWM_A_IEN:  bus_rdata = 32'(ien_q);
      TWM_A_STS:  bus_rdata = 32'({sts_i, 1'b0});
      default:    bus_rdata = '0;
    endcase
    for (int w = 0; w < NWORD; w++) begin
      if (bus_addr == data_addr(w)) bus_rdata = 32'(data_pad[w*PAIR_W +: PAIR_W]);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == thr_addr(c)) bus_rdata = 32'(thr_q[c]);
    end
  end

  assign unused_wdata = ^bus_wdata;

  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (clr_o != '0) |-> bus_wr) else $error("clear without write"); // R7

endmodule

// File: rtl/twm_chan.sv
module twm_chan
  import twm_pkg::*;
#(
  parameter int unsigned CODE_W = TWM_CODE_W,
  parameter int unsigned FILT_W = TWM_FILT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [FILT_W-1:0] filt_i,
  input  logic [CODE_W-1:0] hi_i,
  input  logic [CODE_W-1:0] lo_i,
  input  logic              smp_take_i,
  input  logic [CODE_W-1:0] smp_code_i,
  input  logic [1:0]        clr_i,
  output logic [CODE_W-1:0] data_o,
  output logic [1:0]        sts_o
);

  localparam logic [FILT_W-1:0] RUN_MAX = '1;

  twm_cls_e          cls, run_cls_q;
  logic [FILT_W-1:0] run_q, run_d;
  logic              take;
  logic [1:0]        evt;
  logic [CODE_W-1:0] data_q;
  logic [1:0]        sts_q;

  always_comb begin
    take = smp_take_i && en_i;
    if (smp_code_i > hi_i)      cls = TWM_CLS_HI;
    else if (smp_code_i < lo_i) cls = TWM_CLS_LO;
    else                        cls = TWM_CLS_IN;
    // run length minus one, saturating
    if (cls == run_cls_q) run_d = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    else                  run_d = '0;
    evt = 2'b00;
    if (take && run_d >= filt_i) begin
      evt[0] = (cls == TWM_CLS_HI);
      evt[1] = (cls == TWM_CLS_LO);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      sts_q     <= 2'b00;
      run_q     <= '0;
      run_cls_q <= TWM_CLS_IN;
    end else begin
      sts_q <= (sts_q & ~clr_i) | evt;   // event beats clear
      if (take) begin
        data_q    <= smp_code_i;
        run_q     <= run_d;
        run_cls_q <= cls;
      end
    end
  end

  assign data_o = data_q;
  assign sts_o  = sts_q;

  AST_DIS_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(data_q)) else $error("disabled data moved"); // R3
  AST_DIS_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
    (!en_i && sts_q == 2'b00) |=> (sts_q == 2'b00)) else $error("disabled raised"); // R3
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sts_q[0] && !clr_i[0]) |=> sts_q[0]) else $error("flag lost"); // R7
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (evt[1] && clr_i[1]) |=> sts_q[1]) else $error("event lost to clear"); // R8
  AST_NO_HI_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (take && smp_code_i <= hi_i && !sts_q[0] && !evt[0]) |=> !sts_q[0]) else $error("hi at limit"); // R5

endmodule

// File: rtl/twm_irq.sv
module twm_irq #(
  parameter int unsigned ST_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gen_i,
  input  logic [ST_W-1:0] mask_i,
  input  logic [ST_W-1:0] sts_i,
  output logic            irq_o
);

  logic [ST_W-1:0] live;

  assign live  = sts_i & ~mask_i;
  assign irq_o = gen_i && (|live);

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (sts_i != '0)) else $error("irq without flag"); // R9
  AST_IRQ_QUIET_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (sts_i == '0) |-> !irq_o) else $error("irq with empty status"); // R9

endmodule

// File: rtl/thermal_watch.sv
module thermal_watch
  import twm_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CODE_W = TWM_CODE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic [TWM_ADDR_W-1:0]     bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_CH-1:0]         smp_valid,
  input  logic [NUM_CH*CODE_W-1:0]  smp_code,
  output logic [NUM_CH-1:0]         smp_ready,
  output logic                      irq
);

  localparam int unsigned ST_W = 2*NUM_CH;

  logic [NUM_CH-1:0]        ch_en;
  logic [TWM_FILT_W-1:0]    filt;
  logic [NUM_CH*CODE_W-1:0] thr_hi, thr_lo, data_all;
  logic [ST_W-1:0]          mask, clr, sts_all;
  logic                     gen;

  assign smp_ready = {NUM_CH{~rst}};

  twm_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_data_i (data_all),
    .sts_i     (sts_all),
    .ch_en_o   (ch_en),
    .filt_o    (filt),
    .thr_hi_o  (thr_hi),
    .thr_lo_o  (thr_lo),
    .mask_o    (mask),
    .gen_o     (gen),
    .clr_o     (clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    twm_chan #(.CODE_W(CODE_W), .FILT_W(TWM_FILT_W)) i_chan (
      .clk        (clk),
      .rst        (rst),
      .en_i       (ch_en[c]),
      .filt_i     (filt),
      .hi_i       (thr_hi[c*CODE_W +: CODE_W]),
      .lo_i       (thr_lo[c*CODE_W +: CODE_W]),
      .smp_take_i (smp_valid[c] && smp_ready[c]),
      .smp_code_i (smp_code[c*CODE_W +: CODE_W]),
      .clr_i      (clr[2*c +: 2]),
      .data_o     (data_all[c*CODE_W +: CODE_W]),
      .sts_o      (sts_all[2*c +: 2])
    );
  end

  twm_irq #(.ST_W(ST_W)) i_irq (
    .clk    (clk),
    .rst    (rst),
    .gen_i  (gen),
    .mask_i (mask),
    .sts_i  (sts_all),
    .irq_o  (irq)
  );

  AST_READY_RESET: assert property (@(posedge clk)
    rst |-> (smp_ready == '0)) else $error("ready in reset"); // R11

endmodule

// File: tb/test_thermal_watch.sv
module test_thermal_watch;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_addr = 8'h00;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    smp_valid = '0;
  logic [NCH*CW-1:0] smp_code = '0;
  logic [NCH-1:0]    smp_ready;
  logic              irq;

  int checks = 0;
  int fails  = 0;

  logic [4:0]  m_en;
  logic [23:0] m_time;
  logic [10:0] m_ien;
  logic [9:0]  m_sts;
  logic [15:0] m_data [NCH];
  logic [15:0] m_hi   [NCH];
  logic [15:0] m_lo   [NCH];
  int          m_cls  [NCH];
  int          m_run  [NCH];

  thermal_watch i_thermal_watch (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
    .smp_code(smp_code), .smp_ready(smp_ready), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic model_reset();
    m_en = '0; m_time = '0; m_ien = 11'h7FE; m_sts = '0;
    for (int c = 0; c < NCH; c++) begin
      m_data[c] = '0; m_hi[c] = 16'hFFFF; m_lo[c] = '0; m_cls[c] = 0; m_run[c] = 0;
    end
  endtask

  task automatic model_step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                            input logic [4:0] v, input logic [79:0] codes);
    logic [9:0]  evt;
    logic [9:0]  clr;
    logic [15:0] code;
    int          f;
    int          cls;
    evt = '0; clr = '0;
    f = int'(m_time[21:20]);
    for (int c = 0; c < NCH; c++) begin
      if (v[c] && m_en[c]) begin
        code = codes[c*CW +: CW];
        cls = (code > m_hi[c]) ? 1 : ((code < m_lo[c]) ? 2 : 0);
        if (cls == m_cls[c]) m_run[c] = (m_run[c] == 3) ? 3 : m_run[c] + 1;
        else m_run[c] = 0;
        m_cls[c] = cls;
        m_data[c] = code;
        if (cls == 1 && m_run[c] >= f) evt[2*c] = 1'b1;
        if (cls == 2 && m_run[c] >= f) evt[2*c+1] = 1'b1;
      end
    end
    if (wr) begin
      if (a == 8'h08) m_en = d[4:0];
      if (a == 8'h0C) m_time = d[23:0];
      if (a == 8'h10) clr = d[10:1];
      if (a == 8'h14) m_ien = d[10:0];
      for (int c = 0; c < NCH; c++) begin
        if (a == 8'(8'h40 + 4*c)) begin
          m_hi[c] = d[31:16];
          m_lo[c] = d[15:0];
        end
      end
    end
    m_sts = (m_sts & ~clr) | evt;
  endtask

  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [4:0] v, input logic [79:0] codes);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; smp_valid = v; smp_code = codes;
    @(posedge clk);
    model_step(wr, a, d, v, codes);
    @(negedge clk);
    bus_wr = 1'b0; smp_valid = '0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d, 5'b0, '0);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    logic        exp_irq;
    exp_irq = m_ien[0] && (|(m_sts & ~m_ien[10:1]));
    chk({tag, " R9 irq"}, {31'b0, irq}, {31'b0, exp_irq});
    rd(8'h18, v); chk({tag, " R7 status"}, v, {21'b0, m_sts, 1'b0});
    rd(8'h20, v); chk({tag, " R2 word0"}, v, {m_data[1], m_data[0]});
    rd(8'h24, v); chk({tag, " R2 word1"}, v, {m_data[3], m_data[2]});
    rd(8'h28, v); chk({tag, " R2 word2"}, v, {16'h0, m_data[4]});
  endtask

  function automatic logic [79:0] all_codes(input int base, input int inc);
    logic [79:0] r;
    for (int c = 0; c < NCH; c++) r[c*CW +: CW] = 16'(base + inc*c);
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [79:0] codes;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // reset state
    chk("R11 ready in reset", {27'b0, smp_ready}, 32'h0);
    rd(8'h08, v); chk("R1 enable", v, 32'h0);
    rd(8'h0C, v); chk("R1 timing", v, 32'h0);
    rd(8'h14, v); chk("R1 int ctrl", v, 32'h7FE);
    rd(8'h18, v); chk("R1 status", v, 32'h0);
    rd(8'h40, v); chk("R1 limit0", v, 32'hFFFF0000);
    rd(8'h50, v); chk("R1 limit4", v, 32'hFFFF0000);
    rd(8'h24, v); chk("R1 data", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst = 1'b0;
    #1;
    chk("R11 ready after reset", {27'b0, smp_ready}, 32'h1F);

    // timing register width
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R10 timing upper bits", v, 32'h00FF_FFFF);
    wr_reg(8'h0C, 32'h0);

    // limits
    for (int c = 0; c < NCH; c++) wr_reg(8'(8'h40 + 4*c), {16'(363 + c), 16'd298});
    for (int c = 0; c < NCH; c++) begin
      rd(8'(8'h40 + 4*c), v);
      chk("R4 limit readback", v, {16'(363 + c), 16'd298});
    end

    // disabled channels ignore samples
    step(1'b0, 8'h0, 32'h0, 5'h1F, all_codes(400, 0));
    rd(8'h18, v); chk("R3 disabled status", v, 32'h0);
    rd(8'h20, v); chk("R3 disabled data", v, 32'h0);
    check_all("R3");

    // enable, unmask, inside codes, packing
    wr_reg(8'h08, 32'h1F);
    wr_reg(8'h14, 32'h1);
    step(1'b0, 8'h0, 32'h0, 5'h1F, all_codes(300, 1));
    rd(8'h20, v); chk("R2 pack ch0/ch1", v, 32'h012D_012C);
    rd(8'h24, v); chk("R2 pack ch2/ch3", v, 32'h012F_012E);
    rd(8'h28, v); chk("R2 pack ch4", v, 32'h0000_0130);
    check_all("R2");

    // strict comparisons
    codes = all_codes(300, 0); codes[2*CW +: CW] = 16'd365;
    step(1'b0, 8'h0, 32'h0, 5'b00100, codes);
    rd(8'h18, v); chk("R5 equal high", v, 32'h0);
    codes[2*CW +: CW] = 16'd366;
    step(1'b0, 8'h0, 32'h0, 5'b00100, codes);
    rd(8'h18, v); chk("R5 above high", v, 32'h20);
    codes[3*CW +: CW] = 16'd298;
    step(1'b0, 8'h0, 32'h0, 5'b01000, codes);
    rd(8'h18, v); chk("R5 equal low", v, 32'h20);
    codes[3*CW +: CW] = 16'd297;
    step(1'b0, 8'h0, 32'h0, 5'b01000, codes);
    rd(8'h18, v); chk("R5 below low", v, 32'h120);
    chk("R9 irq on", {31'b0, irq}, 32'h1);
    check_all("R5");

    // masks, global enable, clear
    wr_reg(8'h14, 32'h61);
    chk("R9 one channel masked", {31'b0, irq}, 32'h1);
    wr_reg(8'h14, 32'h1E1);
    chk("R9 all set flags masked", {31'b0, irq}, 32'h0);
    rd(8'h18, v); chk("R7 sticky under mask", v, 32'h120);
    wr_reg(8'h14, 32'h0);
    chk("R9 global off", {31'b0, irq}, 32'h0);
    wr_reg(8'h14, 32'h1);
    chk("R9 global on", {31'b0, irq}, 32'h1);
    wr_reg(8'h18, 32'h7FE);
    rd(8'h18, v); chk("R7 status write ignored", v, 32'h120);
    wr_reg(8'h10, 32'h60);
    rd(8'h18, v); chk("R7 clear ch2", v, 32'h100);
    rd(8'h10, v); chk("R7 clear reads zero", v, 32'h0);
    wr_reg(8'h10, 32'h180);
    rd(8'h18, v); chk("R7 clear ch3", v, 32'h0);
    check_all("R7");

    // event and clear in one cycle
    codes = all_codes(300, 0); codes[0 +: CW] = 16'd400;
    step(1'b1, 8'h10, 32'h6, 5'b00001, codes);
    rd(8'h18, v); chk("R8 set beats clear", v, 32'h2);
    check_all("R8");
    wr_reg(8'h10, 32'h7FE);

    // filter F=2
    wr_reg(8'h0C, 32'h0020_0000);
    codes = all_codes(300, 0); codes[1*CW +: CW] = 16'd400;
    step(1'b0, 8'h0, 32'h0, 5'b00010, codes);
    step(1'b0, 8'h0, 32'h0, 5'b00010, codes);
    rd(8'h18, v); chk("R6 two in a row", v, 32'h0);
    codes[1*CW +: CW] = 16'd320;
    step(1'b0, 8'h0, 32'h0, 5'b00010, codes);
    codes[1*CW +: CW] = 16'd400;
    step(1'b0, 8'h0, 32'h0, 5'b00010, codes);
    step(1'b0, 8'h0, 32'h0, 5'b00010, codes);
    rd(8'h18, v); chk("R6 run restarted", v, 32'h0);
    step(1'b0, 8'h0, 32'h0, 5'b00010, codes);
    rd(8'h18, v); chk("R6 third in a row", v, 32'h8);
    check_all("R6");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [4:0]  rv;
      logic [79:0] rc;
      logic [31:0] d;
      logic [7:0]  a;
      bit          w;
      int          k;
      int          ch;
      rv = 5'($urandom);
      for (int c = 0; c < NCH; c++) rc[c*CW +: CW] = 16'(250 + ($urandom % 200));
      k = int'($urandom % 10);
      w = 1'b1; a = 8'h00; d = '0;
      ch = int'($urandom % NCH);
      case (k)
        0: begin a = 8'h08; d = $urandom; end
        1: begin a = 8'h10; d = $urandom; end
        2: begin a = 8'h14; d = $urandom | 32'h1; end
        3, 4: begin a = 8'(8'h40 + 4*ch);
                 d = {16'(330 + ($urandom % 90)), 16'(260 + ($urandom % 70))}; end
        5: begin a = 8'h0C; d = {10'b0, 2'($urandom), 20'($urandom)}; end
        default: w = 1'b0;
      endcase
      step(w, a, d, rv, rc);
      check_all("RND R3 R5 R6 R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule